// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects up to 32 interrupt request lines, keeps enable, pending and active state for each of them, and offers one processor the most urgent request that may be taken. Each interrupt carries a priority value in which a smaller number means more urgency. Software programs the controller through a word-wide register bus. Enable and pending state each have a pair of registers: one sets bits where ones are written and the other clears them. Priorities sit four to a word and can be written one byte at a time.

The processor side is a request/acknowledge/end-of-service handshake. While `irq_req` is high, `irq_id` names the selected interrupt. An acknowledge moves that interrupt from pending to active. An end-of-service strobe with an interrupt number clears its active bit. Three things hold a request back: a global mask bit, a nonzero priority threshold, and the running priority (the most urgent priority among the interrupts being serviced). A request line that is high sets pending whenever its interrupt is not active. A line that is still high when service ends therefore becomes pending again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A bus write to word 0 sets every enable bit where the data holds a one. A write to word 1 clears every enable bit where the data holds a one. Reads of word 0 and word 1 both return the enable bits.
- R2: Words 2 and 3 work the same way for pending state (2 sets, 3 clears), and both read back the pending bits. Pending can be set while the interrupt is disabled.
- R3: The priority of interrupt N sits in word 8 + N/4, byte N mod 4, in bits [7:4] of that byte. Bits [3:0] of each byte read as zero. A byte is written only when its bus byte strobe is high.
- R4: `irq_req` is high only when some interrupt is both enabled and pending and no mask below applies. `irq_id` is then the one with the smallest priority value. On a tie, the lower interrupt number wins.
- R5: Word 5, bits [7:4], holds a threshold. When it is nonzero, no interrupt whose priority value is equal to or greater than it is requested.
- R6: Word 6, bit 0, is a global mask. While it is set, `irq_req` stays low.
- R7: `irq_ack` while `irq_req` is high clears the pending bit and sets the active bit of `irq_id`, both visible after that clock edge. Word 4 is read-only and returns the active bits.
- R8: `eoi` clears the active bit of interrupt `eoi_id` at the clock edge.
- R9: A high `irq_lines` bit sets the pending bit of its interrupt at each clock edge after which that interrupt is not active, even when the interrupt is disabled. While the interrupt is active, the line does not set pending. A line still high at end of service makes the interrupt pending again.
- R10: While any interrupt is active, a request is offered only when its priority value is strictly smaller than the smallest priority value among the active interrupts.
- R11: After reset, all enable, pending, active, priority, threshold and mask state reads as zero and `irq_req` is low. Unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (5) | Register word address, also selects read data |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, honoured by the priority words |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_lines | input | NUM_IRQ (32) | Level-sensitive request inputs |
| irq_req | output | 1 | An interrupt is offered to the processor |
| irq_id | output | ID_W (5) | Number of the offered interrupt |
| irq_ack | input | 1 | Processor takes the offered interrupt |
| eoi | input | 1 | End of service strobe |
| eoi_id | input | ID_W (5) | Interrupt whose service ends |

## Verification
The hardest situation to reach from the ports is the interaction of several holds at once. One case is an interrupt that is active while others are pending at equal, higher and lower urgency. Another is a level line that is still high at the very edge where service ends, possibly in the same cycle as a new acknowledge. A directed sequence builds these one step at a time: a tie, the threshold at equality, the running priority at equality, and a level line held through end of service. A long random phase with a fixed seed then mixes enable, pending and priority byte writes with line toggles, acknowledges and end-of-service strobes. Every cycle is compared with a model computed in the bench from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Register word offsets; the priority words start at a fixed base.
  localparam int OFS_EN_SET    = 0;
  localparam int OFS_EN_CLR    = 1;
  localparam int OFS_PD_SET    = 2;
  localparam int OFS_PD_CLR    = 3;
  localparam int OFS_ACTIVE    = 4;
  localparam int OFS_THRESH    = 5;
  localparam int OFS_GMASK     = 6;
  localparam int OFS_PRIO_BASE = 8;
  localparam int BYTES_PER_WORD = 4;
endpackage

// File: rtl/pic_prio_bank.sv
module pic_prio_bank #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wdata,
  input  logic [3:0]                   be,
  output logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat,
  output logic [31:0]                  rd_word
);
  import pic_pkg::*;

  localparam int NWORDS = NUM_IRQ / BYTES_PER_WORD;

  logic [NWORDS-1:0][31:0] word_img;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic word_hit;
    assign word_hit = (addr == ADDR_W'(OFS_PRIO_BASE + w));

    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      localparam int IDX = w * BYTES_PER_WORD + b;
      logic                 fld_we;
      logic [PRIO_BITS-1:0] fld_q;
      logic [PRIO_BITS-1:0] fld_d;

      assign fld_we = wr && word_hit && be[b];
      assign fld_d  = fld_we ? wdata[b*8+7 -: PRIO_BITS] : fld_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
      end

      assign prio_flat[IDX*PRIO_BITS +: PRIO_BITS] = fld_q;
      assign word_img[w][b*8 +: 8] = 8'(fld_q) << (8 - PRIO_BITS);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (addr == ADDR_W'(OFS_PRIO_BASE + w)) rd_word = word_img[w];
    end
  end
endmodule

// File: rtl/pic_min_select.sv
module pic_min_select #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IRQ-1:0]           mask,
  input  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat,
  output logic                         sel_valid,
  output logic [ID_W-1:0]              sel_id,
  output logic [PRIO_BITS-1:0]         sel_prio
);
  // Linear scan: a strictly smaller value replaces the best so far,
  // so equal values keep the lower index.
  always_comb begin
    sel_valid = 1'b0;
    sel_id    = '0;
    sel_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (mask[i] && (!sel_valid || (prio_flat[i*PRIO_BITS +: PRIO_BITS] < sel_prio))) begin
        sel_valid = 1'b1;
        sel_id    = ID_W'(i);
        sel_prio  = prio_flat[i*PRIO_BITS +: PRIO_BITS];
      end
    end
  end

  a_r4_pick_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> mask[sel_id]);
  a_r4_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !sel_valid);
endmodule

// File: rtl/pic_line_state.sv
module pic_line_state #(
  parameter int NUM_IRQ = 32,
  parameter int ID_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] en_set,
  input  logic [NUM_IRQ-1:0] en_clr,
  input  logic [NUM_IRQ-1:0] pd_set,
  input  logic [NUM_IRQ-1:0] pd_clr,
  input  logic [NUM_IRQ-1:0] lines,
  input  logic               take,
  input  logic [ID_W-1:0]    take_id,
  input  logic               eoi,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [NUM_IRQ-1:0] enable,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] active
);
  logic [NUM_IRQ-1:0] enable_d, pending_d, active_d;

  always_comb begin
    enable_d = (enable | en_set) & ~en_clr;

    active_d = active;
    if (eoi)  active_d[eoi_id]  = 1'b0;
    if (take) active_d[take_id] = 1'b1;

    pending_d = (pending | pd_set) & ~pd_clr;
    if (take) pending_d[take_id] = 1'b0;
    pending_d = pending_d | (lines & ~active_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= '0;
      pending <= '0;
      active  <= '0;
    end else begin
      enable  <= enable_d;
      pending <= pending_d;
      active  <= active_d;
    end
  end

  a_r1_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(en_set) & ~$past(en_clr) & ~enable) == '0));
  a_r7_take_activates: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> active[$past(take_id)]);
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(take && (take_id == eoi_id))) |=> !active[$past(eoi_id)]);
  a_r9_line_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(lines) & ~active & ~pending) == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 5,
  parameter int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [3:0]         bus_be,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_lines,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  input  logic               irq_ack,
  input  logic               eoi,
  input  logic [ID_W-1:0]    eoi_id
);
  import pic_pkg::*;

  localparam int PF_W = NUM_IRQ * PRIO_BITS;

  // ---------------- register decode ----------------
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr;
  logic               thr_we, gm_we;

  always_comb begin
    en_set = (bus_wr && bus_addr == ADDR_W'(OFS_EN_SET)) ? bus_wdata[NUM_IRQ-1:0] : '0;
    en_clr = (bus_wr && bus_addr == ADDR_W'(OFS_EN_CLR)) ? bus_wdata[NUM_IRQ-1:0] : '0;
    pd_set = (bus_wr && bus_addr == ADDR_W'(OFS_PD_SET)) ? bus_wdata[NUM_IRQ-1:0] : '0;
    pd_clr = (bus_wr && bus_addr == ADDR_W'(OFS_PD_CLR)) ? bus_wdata[NUM_IRQ-1:0] : '0;
    thr_we = bus_wr && (bus_addr == ADDR_W'(OFS_THRESH));
    gm_we  = bus_wr && (bus_addr == ADDR_W'(OFS_GMASK));
  end

  // ---------------- threshold and global mask ----------------
  logic [PRIO_BITS-1:0] thr_q, thr_d;
  logic                 gmask_q, gmask_d;

  always_comb begin
    thr_d   = thr_we ? bus_wdata[7 -: PRIO_BITS] : thr_q;
    gmask_d = gm_we  ? bus_wdata[0]              : gmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      gmask_q <= 1'b0;
    end else begin
      thr_q   <= thr_d;
      gmask_q <= gmask_d;
    end
  end

  // ---------------- priority storage ----------------
  logic [PF_W-1:0] prio_flat;
  logic [31:0]     prio_rd;

  pic_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .prio_flat(prio_flat), .rd_word(prio_rd)
  );

  // ---------------- per-line state ----------------
  logic [NUM_IRQ-1:0] enable, pending, active;
  logic               take;

  pic_line_state #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .lines(irq_lines), .take(take), .take_id(irq_id),
    .eoi(eoi), .eoi_id(eoi_id),
    .enable(enable), .pending(pending), .active(active)
  );

  // ---------------- arbitration ----------------
  logic                 win_valid, act_valid;
  logic [ID_W-1:0]      win_id, act_id;
  logic [PRIO_BITS-1:0] win_prio, act_prio;

  pic_min_select #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_win (
    .clk(clk), .rst_n(rst_n), .mask(enable & pending), .prio_flat(prio_flat),
    .sel_valid(win_valid), .sel_id(win_id), .sel_prio(win_prio)
  );

  // Running priority: most urgent value among interrupts in service.
  pic_min_select #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_run (
    .clk(clk), .rst_n(rst_n), .mask(active), .prio_flat(prio_flat),
    .sel_valid(act_valid), .sel_id(act_id), .sel_prio(act_prio)
  );

  logic blk_thr, blk_run;

  always_comb begin
    blk_thr = (thr_q != '0) && (win_prio >= thr_q);
    blk_run = act_valid && (win_prio >= act_prio);
    irq_req = win_valid && !gmask_q && !blk_thr && !blk_run;
    irq_id  = win_id;
    take    = irq_ack && irq_req;
  end

  // ---------------- read mux ----------------
  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_EN_SET), ADDR_W'(OFS_EN_CLR): bus_rdata = 32'(enable);
      ADDR_W'(OFS_PD_SET), ADDR_W'(OFS_PD_CLR): bus_rdata = 32'(pending);
      ADDR_W'(OFS_ACTIVE): bus_rdata = 32'(active);
      ADDR_W'(OFS_THRESH): bus_rdata = 32'(thr_q) << (8 - PRIO_BITS);
      ADDR_W'(OFS_GMASK):  bus_rdata = 32'(gmask_q);
      default:             bus_rdata = prio_rd;
    endcase
  end

  // ---------------- assertions ----------------
  a_r4_req_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (enable[irq_id] && pending[irq_id]));
  a_r5_threshold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && thr_q != '0) |-> (prio_flat[irq_id*PRIO_BITS +: PRIO_BITS] < thr_q));
  a_r6_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> !irq_req);
  a_r10_running_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && act_valid) |->
      (prio_flat[irq_id*PRIO_BITS +: PRIO_BITS] < prio_flat[act_id*PRIO_BITS +: PRIO_BITS]));
  a_r7_take_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pd_set[irq_id]) |=> !pending[$past(irq_id)]);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines = '0;
  logic        irq_req;
  logic [4:0]  irq_id;
  logic        irq_ack = 1'b0;
  logic        eoi = 1'b0;
  logic [4:0]  eoi_id = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_req(irq_req), .irq_id(irq_id),
    .irq_ack(irq_ack), .eoi(eoi), .eoi_id(eoi_id)
  );

  // ---------------- model state ----------------
  logic [31:0] m_en = '0, m_pend = '0, m_act = '0;
  logic [3:0]  m_prio [32];
  logic [3:0]  m_thr = '0;
  logic        m_gm = 1'b0;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r = '0;
    case (a)
      5'd0, 5'd1: r = m_en;
      5'd2, 5'd3: r = m_pend;
      5'd4:       r = m_act;
      5'd5:       r = {24'd0, m_thr, 4'd0};
      5'd6:       r = {31'd0, m_gm};
      default: if (a >= 5'd8 && a < 5'd16)
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = {m_prio[(a-8)*4+b], 4'd0};
    endcase
    return r;
  endfunction

  // Most urgent enabled+pending interrupt, lower number on ties (R4).
  function automatic int m_winner();
    int best = -1;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && m_pend[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    return best;
  endfunction

  function automatic logic m_req();
    int w = m_winner();
    int run = 16;
    if (w < 0 || m_gm) return 1'b0;
    if (m_thr != 0 && m_prio[w] >= m_thr) return 1'b0;
    for (int i = 0; i < 32; i++) if (m_act[i] && m_prio[i] < run) run = m_prio[i];
    return (m_prio[w] < run);
  endfunction

  task automatic model_update();
    logic [31:0] pset = '0, pclr = '0, act_n, pend_n;
    logic tk = irq_ack && m_req();
    int tid = m_winner();
    if (bus_wr) begin
      case (bus_addr)
        5'd0: m_en = m_en | bus_wdata;
        5'd1: m_en = m_en & ~bus_wdata;
        5'd2: pset = bus_wdata;
        5'd3: pclr = bus_wdata;
        5'd5: m_thr = bus_wdata[7:4];
        5'd6: m_gm = bus_wdata[0];
        default: if (bus_addr >= 5'd8 && bus_addr < 5'd16)
          for (int b = 0; b < 4; b++)
            if (bus_be[b]) m_prio[(bus_addr-8)*4+b] = bus_wdata[b*8+4 +: 4];
      endcase
    end
    act_n = m_act;
    if (eoi) act_n[eoi_id] = 1'b0;
    if (tk) act_n[tid] = 1'b1;
    pend_n = (m_pend | pset) & ~pclr;
    if (tk) pend_n[tid] = 1'b0;
    pend_n = pend_n | (irq_lines & ~act_n);
    m_act = act_n;
    m_pend = pend_n;
  endtask

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare outputs with the model at the current sample point.
  task automatic compare(input string tag);
    logic er = m_req();
    expect32({tag, " rdata"}, bus_rdata, m_read(bus_addr));
    expect32({tag, " irq_req"}, 32'(irq_req), 32'(er));
    if (er) expect32({tag, " irq_id"}, 32'(irq_id), 32'(m_winner()));
  endtask

  task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic ack, input logic eo,
                      input logic [4:0] eid, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    irq_ack = ack; eoi = eo; eoi_id = eid;
    #2;
    compare(tag);
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    step(1'b1, a, d, be, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic peek(input logic [4:0] a, input logic [31:0] exp_rd, input logic exp_req,
                      input logic [4:0] exp_id, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; irq_ack = 1'b0; eoi = 1'b0;
    #2;
    expect32({tag, " rdata"}, bus_rdata, exp_rd);
    expect32({tag, " irq_req"}, 32'(irq_req), 32'(exp_req));
    if (exp_req) expect32({tag, " irq_id"}, 32'(irq_id), 32'(exp_id));
    compare({tag, " model"});
    @(posedge clk);
    #1;
    model_update();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R11: reset state
    for (int a = 0; a < 17; a++) peek(5'(a), 32'd0, 1'b0, '0, "R11 reset");

    // R3: low bits read zero, byte strobes honoured
    wr_reg(5'd8, 32'hFFFF_FFFF, 4'b0001, "R3 byte write");
    peek(5'd8, 32'h0000_00F0, 1'b0, '0, "R3 low bits zero");
    wr_reg(5'd8, 32'h3020_1050, 4'b1111, "R3 word write");
    peek(5'd8, 32'h3020_1050, 1'b0, '0, "R3 readback");

    // R1: enable set/clear pair
    wr_reg(5'd0, 32'h0000_000F, 4'hF, "R1 set");
    peek(5'd1, 32'h0000_000F, 1'b0, '0, "R1 read via clear word");
    wr_reg(5'd1, 32'h0000_0001, 4'hF, "R1 clear");
    peek(5'd0, 32'h0000_000E, 1'b0, '0, "R1 read via set word");

    // R2: pending while disabled
    wr_reg(5'd2, 32'h0000_0001, 4'hF, "R2 set disabled");
    peek(5'd3, 32'h0000_0001, 1'b0, '0, "R2 pending disabled no req");

    // R4: selection and tie
    wr_reg(5'd2, 32'h0000_0006, 4'hF, "R4 set");
    peek(5'd2, 32'h0000_0007, 1'b1, 5'd1, "R4 most urgent");
    wr_reg(5'd8, 32'h0010_0000, 4'b0100, "R4 make tie");
    peek(5'd8, 32'h3010_1050, 1'b1, 5'd1, "R4 tie lower number");

    // R5: threshold equality blocks, larger threshold passes
    wr_reg(5'd5, 32'h0000_0010, 4'hF, "R5 thr 1");
    peek(5'd5, 32'h0000_0010, 1'b0, '0, "R5 equal blocked");
    wr_reg(5'd5, 32'h0000_0020, 4'hF, "R5 thr 2");
    peek(5'd5, 32'h0000_0020, 1'b1, 5'd1, "R5 below passes");

    // R6: global mask
    wr_reg(5'd6, 32'h0000_0001, 4'hF, "R6 mask on");
    peek(5'd6, 32'h0000_0001, 1'b0, '0, "R6 masked");
    wr_reg(5'd6, 32'h0000_0000, 4'hF, "R6 mask off");

    // R7: acknowledge
    step(1'b0, 5'd4, '0, '0, 1'b1, 1'b0, '0, "R7 ack");
    peek(5'd4, 32'h0000_0002, 1'b0, '0, "R7 active set R10 equal blocked");
    peek(5'd2, 32'h0000_0005, 1'b0, '0, "R7 pending cleared");

    // R10: strictly more urgent preempts
    wr_reg(5'd8, 32'h0000_0000, 4'b0100, "R10 raise irq2");
    peek(5'd4, 32'h0000_0002, 1'b1, 5'd2, "R10 more urgent offered");

    // R8: end of service
    step(1'b0, 5'd4, '0, '0, 1'b0, 1'b1, 5'd1, "R8 eoi");
    peek(5'd4, 32'h0000_0000, 1'b1, 5'd2, "R8 active cleared");

    wr_reg(5'd3, 32'hFFFF_FFFF, 4'hF, "clean pend");
    wr_reg(5'd1, 32'hFFFF_FFFF, 4'hF, "clean en");
    wr_reg(5'd5, 32'h0, 4'hF, "clean thr");

    // R9: level line behaviour
    irq_lines = 32'h0000_0020;
    step(1'b0, 5'd0, '0, '0, 1'b0, 1'b0, '0, "R9 idle");
    peek(5'd2, 32'h0000_0020, 1'b0, '0, "R9 pending while disabled");
    wr_reg(5'd0, 32'h0000_0020, 4'hF, "R9 enable");
    peek(5'd2, 32'h0000_0020, 1'b1, 5'd5, "R9 offered");
    step(1'b0, 5'd4, '0, '0, 1'b1, 1'b0, '0, "R9 ack");
    peek(5'd2, 32'h0000_0000, 1'b0, '0, "R9 no repend while active");
    step(1'b0, 5'd4, '0, '0, 1'b0, 1'b1, 5'd5, "R9 eoi");
    peek(5'd2, 32'h0000_0020, 1'b1, 5'd5, "R9 repend after eoi");
    irq_lines = '0;
    wr_reg(5'd3, 32'h0000_0020, 4'hF, "R9 clear");
    peek(5'd2, 32'h0000_0000, 1'b0, '0, "R9 cleared after line low");

    // Random phase: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 against the model
    void'($urandom(32'd20240517));
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 10;
      logic [31:0] d = $urandom;
      logic [4:0]  a = 5'($urandom % 17);
      logic        wr = 1'b1;
      case (op)
        0: a = 5'd0;
        1: begin a = 5'd1; d = d & $urandom & $urandom; end
        2: begin a = 5'd2; d = d & $urandom & $urandom; end
        3: begin a = 5'd3; d = d & $urandom; end
        4: a = 5'(8 + $urandom % 8);
        5: begin a = 5'd5; if ($urandom % 2) d = 0; end
        6: begin a = 5'd6; d = 32'(($urandom % 5) == 0); end
        default: wr = 1'b0;
      endcase
      if (($urandom % 8) == 0) irq_lines[$urandom % 32] ^= 1'b1;
      step(wr, a, d, 4'($urandom), 1'($urandom), ($urandom % 4) == 0,
           5'($urandom), "R4 R7 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule